// File: doc/BRIEF.md
# Multiplexed Digit Scan Sequencer

This block sequences the time-multiplexed drive of an eight-position character display. A base clock enable (`tick`) feeds a 64-step phase counter; each time the phase counter wraps, a digit index advances by one, so the positions are lit one at a time, left to right, and then the sequence starts again. One complete pass over the eight positions takes 512 ticks. With a 200 kHz tick, each position is refreshed at roughly 400 Hz.

The digit index is also the read address into the character memory, so the font decoder downstream always sees the character of the position that is being driven. At the start of every slot a short blanking window keeps all outputs dark while the select lines change, which prevents ghosting. The window is set by the phase counter. A write-busy flag from the write path darkens the display while it is high, and the scan keeps running. A shutdown request darkens the display, gates off the display-full flag and holds both counters at zero. When shutdown is released, the scan restarts at the first position. The character memory itself is outside this block and keeps its contents.

Top module: `scan_sequencer`

## Requirements
- R1: After reset, `rd_addr` is 0 and `digit_en` and `seg_en` are all low, because the phase counter starts at 0 and is therefore inside the blanking window.
- R2: The phase counter advances only on clock edges where `tick` is high. The digit index advances exactly once per 64 ticks, on the tick that wraps the phase from 63 to 0. Cycles with `tick` low change nothing.
- R3: The positions are visited in the order index 0,1,…,7 and then back to 0. `digit_en` bit i (bit 0 is the leftmost position) is the only bit that can be high while the index is i.
- R4: While the phase value is below `BLANK_TICKS` (default 1, so only phase 0), `digit_en` is all zero.
- R5: While `wr_busy` is high, `digit_en` and `seg_en` are low in the same cycle. The phase and digit counters keep counting.
- R6: While `shutdown` is high, all outputs are low in the same cycle, and at every clock edge both counters are cleared. After release, the scan resumes at index 0 with phase 0.
- R7: `rd_addr` always equals the current digit index, including during blanking, write-busy and shutdown.
- R8: `seg_en` is high exactly when some bit of `digit_en` is high.
- R9: `full_out` follows `full_in` except while `shutdown` is high, when it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Base clock enable that steps the phase counter |
| shutdown | input | 1 | Low-power request: darkens outputs and clears counters |
| wr_busy | input | 1 | Write in progress; darkens outputs |
| full_in | input | 1 | Display-full flag from the write path |
| digit_en | output | DIGITS (8) | One-hot position select, bit 0 = leftmost |
| rd_addr | output | AW (3) | Character memory read address = digit index |
| seg_en | output | 1 | Segment driver enable |
| full_out | output | 1 | Display-full flag, gated by shutdown |

## Verification
The hardest case to reach is a digit wrap that coincides with other events: the index rolls from 7 back to 0 after 512 ticks, and a shutdown that falls in the middle of a slot must drop both counters to zero. The vector table covers both. It runs long tick bursts past a full pass, places write-busy and shutdown windows in the middle of slots, and inserts stretches with `tick` low. A bench reference model steps along with every clock edge, so each cycle is compared, including the first one after shutdown is released and the single blanked phase of each slot.

// File: rtl/scan_pkg.sv
package scan_pkg;

  // True while the phase value lies inside the inter-digit blanking window.
  function automatic logic in_blank(input int unsigned phase, input int unsigned blank_len);
    return phase < blank_len;
  endfunction

  // Next digit index with wrap-around after the last position.
  function automatic int unsigned next_index(input int unsigned idx, input int unsigned count);
    return (idx + 1 >= count) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/scan_prescaler.sv
module scan_prescaler #(
  parameter int unsigned PRESCALE = 64,
  localparam int unsigned PW = $clog2(PRESCALE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          clear,
  output logic [PW-1:0] phase,
  output logic          wrap
);

  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  assign wrap = tick && !clear && (phase == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase <= '0;
    else if (clear)  phase <= '0;
    else if (wrap)   phase <= '0;
    else if (tick)   phase <= phase + 1'b1;
  end

  // R2
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clear) |=> $stable(phase));

endmodule

// File: rtl/scan_digit_counter.sv
module scan_digit_counter #(
  parameter int unsigned DIGITS = 8,
  localparam int unsigned AW = $clog2(DIGITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          clear,
  output logic [AW-1:0] index
);

  import scan_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      index <= '0;
    else if (clear)  index <= '0;
    else if (step)   index <= AW'(next_index(int'(index), DIGITS));
  end

  // R2
  index_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clear) |=> $stable(index));

  // R6
  index_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (index == '0));

endmodule

// File: rtl/scan_output_gate.sv
module scan_output_gate #(
  parameter int unsigned DIGITS = 8,
  localparam int unsigned AW = $clog2(DIGITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     index,
  input  logic              dark,
  output logic [DIGITS-1:0] digit_en,
  output logic              seg_en
);

  logic [DIGITS-1:0] decoded;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dec
    assign decoded[g] = (index == AW'(g));
  end

  assign digit_en = dark ? '0 : decoded;
  assign seg_en   = !dark;

  // R3
  digit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(digit_en));

  // R8
  seg_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_en == (digit_en != '0));

endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer #(
  parameter int unsigned PRESCALE    = 64,
  parameter int unsigned DIGITS      = 8,
  parameter int unsigned BLANK_TICKS = 1,
  localparam int unsigned PW = $clog2(PRESCALE),
  localparam int unsigned AW = $clog2(DIGITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              shutdown,
  input  logic              wr_busy,
  input  logic              full_in,
  output logic [DIGITS-1:0] digit_en,
  output logic [AW-1:0]     rd_addr,
  output logic              seg_en,
  output logic              full_out
);

  import scan_pkg::*;

  logic [PW-1:0] phase;
  logic [AW-1:0] index;
  logic          slot_wrap;
  logic          blanking;
  logic          dark;

  scan_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clear(shutdown),
    .phase(phase), .wrap(slot_wrap)
  );

  scan_digit_counter #(.DIGITS(DIGITS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(slot_wrap), .clear(shutdown),
    .index(index)
  );

  assign blanking = in_blank(int'(phase), BLANK_TICKS);
  assign dark     = blanking || wr_busy || shutdown;

  scan_output_gate #(.DIGITS(DIGITS)) u_gate (
    .clk(clk), .rst_n(rst_n), .index(index), .dark(dark),
    .digit_en(digit_en), .seg_en(seg_en)
  );

  assign rd_addr  = index;
  assign full_out = full_in && !shutdown;

  // R4
  blank_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blanking |-> (digit_en == '0));

  // R5
  busy_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy |-> (digit_en == '0 && !seg_en));

  // R6
  shutdown_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> (phase == '0 && rd_addr == '0));

  // R9
  full_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> !full_out);

  // R7
  addr_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (digit_en != '0) |-> digit_en[rd_addr]);

endmodule

// File: tb/tb_scan_sequencer.sv
module tb_scan_sequencer;

  localparam int PRESCALE = 64;
  localparam int DIGITS   = 8;
  localparam int BLANK    = 1;
  localparam int NROWS    = 11;

  // row: {cycles[15:0], tick, busy, shdn, full}
  localparam logic [19:0] ROWS [NROWS] = '{
    {16'd3,   4'b0000},  // R2 no ticks, nothing moves
    {16'd70,  4'b1000},  // R2 R3 first slot boundary
    {16'd10,  4'b0001},  // R2 tick low holds, R9 full passes
    {16'd500, 4'b1000},  // R3 wrap 7 -> 0
    {16'd5,   4'b1100},  // R5 busy mid slot
    {16'd40,  4'b1000},
    {16'd3,   4'b1011},  // R6 R9 shutdown mid slot
    {16'd130, 4'b1001},  // R6 restart at index 0
    {16'd20,  4'b1100},  // R5 busy across boundary
    {16'd4,   4'b0010},  // R6 shutdown with tick low
    {16'd600, 4'b1000}   // R3 full pass again
  };

  logic clk = 0, rst_n = 0;
  logic tick = 0, shutdown = 0, wr_busy = 0, full_in = 0;
  logic [DIGITS-1:0] digit_en;
  logic [2:0] rd_addr;
  logic seg_en, full_out;

  int checks = 0, fails = 0;
  int m_phase = 0, m_idx = 0;
  bit done = 0;

  always #4 clk = ~clk;

  scan_sequencer dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .shutdown(shutdown),
    .wr_busy(wr_busy), .full_in(full_in), .digit_en(digit_en),
    .rd_addr(rd_addr), .seg_en(seg_en), .full_out(full_out)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    bit dark;
    int exp_en;
    string tag;
    dark = shutdown || wr_busy || (m_phase < BLANK);
    exp_en = dark ? 0 : (1 << m_idx);
    if (shutdown)           tag = "R6 digit_en";
    else if (wr_busy)       tag = "R5 digit_en";
    else if (m_phase < BLANK) tag = "R4 digit_en";
    else                    tag = "R3 digit_en";
    check(tag, int'(digit_en), exp_en);
    check("R7 rd_addr", int'(rd_addr), m_idx);
    check("R8 seg_en", int'(seg_en), dark ? 0 : 1);
    check("R9 full_out", int'(full_out), (full_in && !shutdown) ? 1 : 0);
  endtask

  task automatic model_edge();
    if (shutdown) begin
      m_phase = 0; m_idx = 0;
    end else if (tick) begin
      if (m_phase == PRESCALE - 1) begin
        m_phase = 0;
        m_idx = (m_idx + 1) % DIGITS;
      end else m_phase++;
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rd_addr", int'(rd_addr), 0);
    check("R1 digit_en", int'(digit_en), 0);
    check("R1 seg_en", int'(seg_en), 0);
    rst_n = 1;

    for (int r = 0; r < NROWS; r++) begin
      for (int c = 0; c < int'(ROWS[r][19:4]); c++) begin
        @(negedge clk);
        tick     = ROWS[r][3];
        wr_busy  = ROWS[r][2];
        shutdown = ROWS[r][1];
        full_in  = ROWS[r][0];
        #1;
        check_all();
        @(posedge clk);
        model_edge();
      end
    end

    // R2 directed: exactly 64 ticks move the index by one
    @(negedge clk);
    tick = 0; wr_busy = 0; shutdown = 1; full_in = 0;
    @(posedge clk); model_edge();
    @(negedge clk);
    shutdown = 0; tick = 1;
    repeat (63) begin @(posedge clk); model_edge(); end
    @(negedge clk); #1;
    check("R2 index after 63 ticks", int'(rd_addr), 0);
    @(posedge clk); model_edge();
    @(negedge clk); #1;
    check("R2 index after 64 ticks", int'(rd_addr), 1);
    check("R4 blank at slot start", int'(digit_en), 0);
    @(posedge clk); model_edge();
    @(negedge clk); #1;
    check("R3 second position lit", int'(digit_en), 2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule